// File: doc/BRIEF.md
# Ternary Logic and Three-Operand Add Unit

This block is a 32-bit execution slice with three source operands. In one cycle it computes either any bitwise function of three inputs or the integer sum of all three operands. The bitwise function is chosen by an 8-bit truth-table immediate. Each result bit is picked from that table by an 8-to-1 multiplexer. The multiplexer select is made from the matching bits of the three operands.

Six fixed two-input logic opcodes are also decoded. Each one is mapped onto a hard-wired truth table, so it runs through the same lookup path. The three-operand sum goes through a carry-save reduction first and then a single carry-propagate adder. The two bits of overflow come out on a side output.

An issuing pipeline asserts `in_valid` together with the opcode, the immediate and the operands. Exactly one cycle later the unit presents a registered result with `out_valid`.

Top module: `tla_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_data` and `out_carry` are cleared to zero at that edge.
- R2: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high. It is low in the cycle after an edge that samples `in_valid` low.
- R3: With `in_op` = 3'b000, result bit i equals `in_tbl[{in_a[i], in_b[i], in_c[i]}]`, where `in_a` supplies the most significant index bit.
- R4: With `in_op` = 3'b000, the table 8'hF0 returns `in_a`, 8'hCC returns `in_b` and 8'hAA returns `in_c`.
- R5: With `in_op` = 3'b000, the table 8'hCA gives the bitwise select (a ? b : c), and the table 8'hE8 gives the bitwise majority of a, b and c.
- R6: With `in_op` = 3'b001, `out_data` is (a + b + c) mod 2^32, and `out_carry` holds bits 33:32 of the full 34-bit sum.
- R7: Opcodes 3'b010 to 3'b111 give, in that order, a&b, a|b, a^b, ~(a^b), a&~b and ~(a|b). For these opcodes, both `in_c` and `in_tbl` have no effect on the result.
- R8: `out_carry` is zero after any opcode other than 3'b001.
- R9: `out_data` and `out_carry` keep their values across any cycle in which `in_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_op | input | 3 | Opcode |
| in_tbl | input | 8 | Truth-table immediate, used by opcode 3'b000 only |
| in_a | input | 32 | Source operand A (most significant index bit) |
| in_b | input | 32 | Source operand B |
| in_c | input | 32 | Source operand C |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 32 | Registered result |
| out_carry | output | 2 | Overflow bits of the three-operand sum |

## Verification
The operand patterns 0xFFFF0000, 0xFF00FF00 and 0xF0F0F0F0 cover every index combination on some bit. With these operands, a wrong table index order or a wrong bit weight in the lookup shows up as a mismatch. The selector tables 0xF0, 0xCC and 0xAA are run on unrelated random-looking operands, which tells a swapped select bit apart from a correct one. The select and majority tables are compared against their reference expressions. The sum is tried with no carries, with a carry into bit 32 only, and with all-ones operands that push the overflow to 2, so a dropped carry vector or a misplaced shift is exposed. Legacy opcodes are run with a nonzero C and a random immediate, to show that neither one leaks into the result.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned OPW = 3;
  localparam int unsigned TW  = 8;

  typedef enum logic [OPW-1:0] {
    OP_TTBL = 3'b000,
    OP_SUM3 = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_XNOR = 3'b101,
    OP_ANDN = 3'b110,
    OP_NOR  = 3'b111
  } op_e;

  // Selector masks under index {a,b,c}, a most significant.
  localparam logic [TW-1:0] SEL_A = 8'hF0;
  localparam logic [TW-1:0] SEL_B = 8'hCC;

  localparam logic [TW-1:0] TBL_AND  = SEL_A & SEL_B;
  localparam logic [TW-1:0] TBL_OR   = SEL_A | SEL_B;
  localparam logic [TW-1:0] TBL_XOR  = SEL_A ^ SEL_B;
  localparam logic [TW-1:0] TBL_XNOR = ~(SEL_A ^ SEL_B);
  localparam logic [TW-1:0] TBL_ANDN = SEL_A & ~SEL_B;
  localparam logic [TW-1:0] TBL_NOR  = ~(SEL_A | SEL_B);
endpackage

// File: rtl/tla_opdecode.sv
module tla_opdecode
  import tla_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [TW-1:0]  imm,
  output logic [TW-1:0]  tbl,
  output logic           is_sum
);
  always_comb begin
    is_sum = 1'b0;
    tbl    = imm;
    unique case (op_e'(op))
      OP_TTBL: tbl = imm;
      OP_SUM3: begin tbl = '0; is_sum = 1'b1; end
      OP_AND:  tbl = TBL_AND;
      OP_OR:   tbl = TBL_OR;
      OP_XOR:  tbl = TBL_XOR;
      OP_XNOR: tbl = TBL_XNOR;
      OP_ANDN: tbl = TBL_ANDN;
      OP_NOR:  tbl = TBL_NOR;
      default: tbl = imm;
    endcase
  end
endmodule

// File: rtl/tla_lut3.sv
module tla_lut3 #(
  parameter int unsigned W = 32
) (
  input  logic [7:0]   tbl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] sel;
    assign sel  = {a[i], b[i], c[i]};
    assign y[i] = tbl[sel];
  end
endmodule

// File: rtl/tla_csa_add.sv
module tla_csa_add #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = W + 2
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  c,
  output logic [W-1:0]  sv,
  output logic [W-1:0]  cv,
  output logic [SW-1:0] total
);
  // Carry-save layer: per-bit full adders, no propagation.
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sv[i] = a[i] ^ b[i] ^ c[i];
    assign cv[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end

  // Single carry-propagate add; carry vector weighs twice.
  assign total = {2'b00, sv} + {1'b0, cv, 1'b0};
endmodule

// File: rtl/tla_unit.sv
module tla_unit
  import tla_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     in_op,
  input  logic [7:0]     in_tbl,
  input  logic [31:0]    in_a,
  input  logic [31:0]    in_b,
  input  logic [31:0]    in_c,
  output logic           out_valid,
  output logic [31:0]    out_data,
  output logic [1:0]     out_carry
);
  localparam int unsigned SW = DW + 2;

  logic [TW-1:0] dec_tbl;
  logic          dec_sum;
  logic [DW-1:0] lut_y;
  logic [DW-1:0] csa_s;
  logic [DW-1:0] csa_c;
  logic [SW-1:0] add_total;

  tla_opdecode u_dec (
    .op     (in_op),
    .imm    (in_tbl),
    .tbl    (dec_tbl),
    .is_sum (dec_sum)
  );

  tla_lut3 #(.W(DW)) u_lut (
    .tbl (dec_tbl),
    .a   (in_a),
    .b   (in_b),
    .c   (in_c),
    .y   (lut_y)
  );

  tla_csa_add #(.W(DW)) u_add (
    .a     (in_a),
    .b     (in_b),
    .c     (in_c),
    .sv    (csa_s),
    .cv    (csa_c),
    .total (add_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= dec_sum ? add_total[DW-1:0] : lut_y;
        out_carry <= dec_sum ? add_total[SW-1:DW] : 2'b00;
      end
    end
  end

  // R2: one-cycle valid timing
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4: selector table for A passes A through
  p_sel_a_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_TTBL && in_tbl == SEL_A) |=> out_data == $past(in_a));

  // R6: carry-save vectors preserve the arithmetic sum
  p_csa_invariant_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ({2'b00, csa_s} + {1'b0, csa_c, 1'b0}) ==
                 ({2'b00, in_a} + {2'b00, in_b} + {2'b00, in_c}));

  // R7: legacy tables never depend on C (even/odd entries pair up)
  p_legacy_no_c_r7: assert property (@(posedge clk) disable iff (rst)
    (in_op != OP_TTBL && in_op != OP_SUM3) |->
      ((dec_tbl & 8'h55) == ((dec_tbl >> 1) & 8'h55)));

  // R8: no carry after logic operations
  p_carry_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != OP_SUM3) |=> out_carry == 2'b00);

  // R9: idle cycles keep the result
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_carry)));
endmodule

// File: tb/tla_unit_tb.sv
module tla_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [7:0]  in_tbl;
  logic [31:0] in_a, in_b, in_c;
  logic        out_valid;
  logic [31:0] out_data;
  logic [1:0]  out_carry;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tla_unit u_dut (
    .clk, .rst, .in_valid, .in_op, .in_tbl, .in_a, .in_b, .in_c,
    .out_valid, .out_data, .out_carry
  );

  // {op, tbl, a, b, c}
  localparam int NV = 16;
  localparam logic [106:0] VEC [NV] = '{
    {3'b000, 8'hF0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C},
    {3'b000, 8'hCC, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C},
    {3'b000, 8'hAA, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C},
    {3'b000, 8'h96, 32'hFFFF_0000, 32'hFF00_FF00, 32'hF0F0_F0F0},
    {3'b000, 8'h01, 32'hFFFF_0000, 32'hFF00_FF00, 32'hF0F0_F0F0},
    {3'b000, 8'h80, 32'hFFFF_0000, 32'hFF00_FF00, 32'hF0F0_F0F0},
    {3'b000, 8'hCA, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_BABE},
    {3'b000, 8'hE8, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_BABE},
    {3'b001, 8'h5A, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003},
    {3'b001, 8'h00, 32'h8000_0000, 32'h8000_0000, 32'h0000_0005},
    {3'b010, 8'h3C, 32'hF0F0_1234, 32'hFF00_5678, 32'hFFFF_FFFF},
    {3'b011, 8'hA5, 32'hF0F0_1234, 32'hFF00_5678, 32'h1357_9BDF},
    {3'b100, 8'hFF, 32'hF0F0_1234, 32'hFF00_5678, 32'hFFFF_0000},
    {3'b101, 8'h00, 32'hF0F0_1234, 32'hFF00_5678, 32'hAAAA_5555},
    {3'b110, 8'h77, 32'hF0F0_1234, 32'hFF00_5678, 32'hFFFF_FFFF},
    {3'b111, 8'h12, 32'hF0F0_1234, 32'hFF00_5678, 32'h8765_4321}
  };

  function automatic logic [33:0] ref_model(input logic [2:0] op, input logic [7:0] t,
                                            input logic [31:0] a, b, c);
    logic [31:0] r = '0;
    case (op)
      3'b000: for (int k = 0; k < 8; k++)
                if (t[k]) r |= (k[2] ? a : ~a) & (k[1] ? b : ~b) & (k[0] ? c : ~c);
      3'b001: return {2'b00, a} + {2'b00, b} + {2'b00, c};
      3'b010: r = a & b;
      3'b011: r = a | b;
      3'b100: r = a ^ b;
      3'b101: r = ~(a ^ b);
      3'b110: r = a & ~b;
      default: r = ~(a | b);
    endcase
    return {2'b00, r};
  endfunction

  function automatic string tag(input logic [2:0] op, input logic [7:0] t);
    if (op == 3'b001) return "R6";
    if (op != 3'b000) return "R7";
    if (t == 8'hF0 || t == 8'hCC || t == 8'hAA) return "R4";
    if (t == 8'hCA || t == 8'hE8) return "R5";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] t,
                       input logic [31:0] a, b, c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_tbl = t; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [33:0] e;
    rst = 1'b1; in_valid = 1'b1; in_op = 3'b001; in_tbl = '0;
    in_a = '1; in_b = '1; in_c = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {29'd0, out_valid, out_carry}, 64'd0);
    check("R1", {32'd0, out_data}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [7:0] t; logic [31:0] a, b, c;
      {op, t, a, b, c} = VEC[i];
      e = ref_model(op, t, a, b, c);
      issue(op, t, a, b, c);
      check("R2", {63'd0, out_valid}, 64'd1);
      check(tag(op, t), {32'd0, out_data}, {32'd0, e[31:0]});
      check(op == 3'b001 ? "R6" : "R8", {62'd0, out_carry}, {62'd0, e[33:32]});
    end

    // R5: compare with reference expressions directly
    issue(3'b000, 8'hCA, 32'h6969_A5A5, 32'h1111_EEEE, 32'h7777_0000);
    check("R5", {32'd0, out_data},
          {32'd0, (32'h6969_A5A5 & 32'h1111_EEEE) | (~32'h6969_A5A5 & 32'h7777_0000)});
    issue(3'b000, 8'hE8, 32'h6969_A5A5, 32'h1111_EEEE, 32'h7777_0000);
    check("R5", {32'd0, out_data},
          {32'd0, (32'h6969_A5A5 & 32'h1111_EEEE) | (32'h6969_A5A5 & 32'h7777_0000)
                | (32'h1111_EEEE & 32'h7777_0000)});

    // R6: maximum overflow
    issue(3'b001, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R6", {32'd0, out_data}, {32'd0, 32'hFFFF_FFFD});
    check("R6", {62'd0, out_carry}, 64'd2);

    // R7: C and immediate ignored for a legacy opcode
    issue(3'b100, 8'h00, 32'hAAAA_0000, 32'h0F0F_0F0F, 32'h0000_0000);
    check("R7", {32'd0, out_data}, {32'd0, 32'hA5A5_0F0F});
    issue(3'b100, 8'hFF, 32'hAAAA_0000, 32'h0F0F_0F0F, 32'hFFFF_FFFF);
    check("R7", {32'd0, out_data}, {32'd0, 32'hA5A5_0F0F});

    // R8 after a sum with carry, then a logic op
    issue(3'b001, 8'h00, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0);
    check("R6", {62'd0, out_carry}, 64'd1);
    issue(3'b011, 8'h00, 32'h1, 32'h2, 32'h4);
    check("R8", {62'd0, out_carry}, 64'd0);
    check("R7", {32'd0, out_data}, 64'd3);

    // R9 and R2: idle cycle with changed inputs keeps the result
    @(negedge clk);
    in_op = 3'b001; in_a = 32'h5; in_b = 32'h5; in_c = 32'h5;
    check("R2", {63'd0, out_valid}, 64'd0);
    check("R9", {32'd0, out_data}, 64'd3);
    @(negedge clk);
    check("R9", {62'd0, out_carry}, 64'd0);

    // R2: back-to-back issue
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'b001; in_tbl = '0; in_a = 32'd10; in_b = 32'd20; in_c = 32'd30;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd1);
    check("R6", {32'd0, out_data}, 64'd60);
    in_op = 3'b000; in_tbl = 8'hCC; in_b = 32'hBEEF_0001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, out_valid}, 64'd1);
    check("R4", {32'd0, out_data}, {32'd0, 32'hBEEF_0001});
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);

    // R1: reset in mid-run clears the output
    rst = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, out_valid, out_data}, 64'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule